// File: doc/BRIEF.md
# Power-State Transmit Control Driver

This block sits on the MAC side of a PHY interface whose link power is managed in four states. Each cycle it takes the requested power state and three command inputs: a loopback request, a receiver-detect request and a beacon request. From these it drives two shared transmit control lines, one for detect or loopback and one that forces the transmitter into electrical idle. Both lines are always held at the level that is legal for the current power state. The same detect/loopback line has a different meaning depending on the state: it selects datapath loopback in the full-power state, and it starts a receiver-detect operation in the low-power idle state.

Two small timed sequences run inside the block. A receiver-detect request in the low-power idle state keeps the detect line high until the PHY returns a status-valid pulse or a timeout counter expires, and then reports completion. A beacon request in the deepest state releases the electrical-idle line for a fixed number of cycles. A command that is not permitted in the current state raises an illegal-request flag, and the lines keep their legal levels.

Top module: `pwr_tx_ctrl`

## Requirements
- R1: While reset is asserted, `tx_detect_loop` and `tx_elec_idle` are both 1, and `illegal_req`, `detect_done` and `detect_timeout` are 0.
- R2: The power state is encoded as 2'b00 full power, 2'b01 standby, 2'b10 low-power idle and 2'b11 deep sleep. All outputs are registered and reflect the inputs sampled at the previous rising edge. In full power, `tx_elec_idle` is 0 and `tx_detect_loop` equals `req_loop`.
- R3: In standby, `tx_detect_loop` is 0 and `tx_elec_idle` is 1.
- R4: In low-power idle with no detect operation running, `tx_detect_loop` is 0 and `tx_elec_idle` is 1.
- R5: In deep sleep with no beacon running, `tx_detect_loop` is 0 and `tx_elec_idle` is 1.
- R6: For every cycle in which `req_loop` is high outside full power, `req_detect` is high outside low-power idle, or `req_beacon` is high outside deep sleep, `illegal_req` is 1 in the next cycle. The illegal request does not change either control line.
- R7: A `req_detect` in low-power idle sets `tx_detect_loop` in the next cycle. The line stays set until `detect_status_valid` is sampled high. In the cycle after that sample the line is 0 and `detect_done` pulses with `detect_timeout` at 0.
- R8: If no status arrives, `tx_detect_loop` stays high for exactly DET_TIMEOUT cycles (default 255). It then falls, and `detect_done` and `detect_timeout` pulse together for one cycle.
- R9: A `req_beacon` in deep sleep drives `tx_elec_idle` to 0 for exactly BEACON_LEN cycles (default 16), starting in the next cycle, and then returns it to 1.
- R10: Leaving low-power idle cancels a running detect, and leaving deep sleep cancels a running beacon. Neither cancellation produces `detect_done`, and a later return to that state does not resume the operation.
- R11: A `req_detect` that arrives while a detect is already running is ignored and does not restart the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_state | input | 2 | Requested power state |
| req_loop | input | 1 | Loopback request (level) |
| req_detect | input | 1 | Receiver-detect request |
| req_beacon | input | 1 | Beacon request |
| detect_status_valid | input | 1 | Status-valid response from the PHY |
| tx_detect_loop | output | 1 | Detect/loopback control line |
| tx_elec_idle | output | 1 | Force-electrical-idle control line |
| illegal_req | output | 1 | Request not permitted in the current state |
| detect_done | output | 1 | Detect operation finished (one-cycle pulse) |
| detect_timeout | output | 1 | Detect finished because the timeout expired |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. The bench therefore changes inputs on the falling edge and samples results on the following falling edge. The detect and beacon windows are measured by counting the consecutive falling-edge samples during which the line holds its active level, and the pulse flags are checked on the first sample after the line returns. Cancellation and repeated-request cases are timed the same way, so each result is read in its first valid cycle and in no other.

// File: rtl/pwr_tx_pkg.sv
package pwr_tx_pkg;
  typedef enum logic [1:0] {
    PS_FULL    = 2'b00,
    PS_STANDBY = 2'b01,
    PS_LOWIDLE = 2'b10,
    PS_DEEP    = 2'b11
  } pstate_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_t;
endpackage

// File: rtl/pwr_state_map.sv
module pwr_state_map
  import pwr_tx_pkg::*;
(
  input  logic [1:0] pwr_state,
  input  logic       req_loop,
  input  logic       req_detect,
  input  logic       req_beacon,
  output logic       in_full,
  output logic       in_lowidle,
  output logic       in_deep,
  output logic       illegal
);
  pstate_t st;
  always_comb begin
    st         = pstate_t'(pwr_state);
    in_full    = (st == PS_FULL);
    in_lowidle = (st == PS_LOWIDLE);
    in_deep    = (st == PS_DEEP);
    illegal    = (req_loop   && !in_full)    ||
                 (req_detect && !in_lowidle) ||
                 (req_beacon && !in_deep);
  end
endmodule

// File: rtl/pwr_detect_seq.sv
module pwr_detect_seq
  import pwr_tx_pkg::*;
#(
  parameter int unsigned DET_TIMEOUT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_lowidle,
  input  logic start,
  input  logic status_valid,
  output logic busy_nxt,
  output logic done_q,
  output logic timeout_q
);
  localparam int unsigned CW = (DET_TIMEOUT < 2) ? 1 : $clog2(DET_TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(DET_TIMEOUT - 1);

  seq_t          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d, timeout_d;
  logic          cnt_en;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    done_d    = 1'b0;
    timeout_d = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (in_lowidle && start) begin
          st_d   = SEQ_RUN;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (!in_lowidle) begin
          st_d = SEQ_IDLE;
        end else if (status_valid) begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
        end else if (cnt_q == LAST) begin
          st_d      = SEQ_IDLE;
          done_d    = 1'b1;
          timeout_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    busy_nxt = (st_d == SEQ_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      done_q    <= done_d;
      timeout_q <= timeout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_status_ends_detect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && in_lowidle && status_valid) |=> (done_q && !timeout_q && st_q == SEQ_IDLE));
  p_timeout_ends_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && in_lowidle && !status_valid && cnt_q == LAST) |=> (done_q && timeout_q));
  p_leave_cancels_detect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_lowidle) |=> (st_q == SEQ_IDLE && !done_q));
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && in_lowidle && !status_valid && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwr_beacon_tmr.sv
module pwr_beacon_tmr
  import pwr_tx_pkg::*;
#(
  parameter int unsigned BEACON_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_deep,
  input  logic start,
  output logic active_nxt
);
  localparam int unsigned CW = (BEACON_LEN < 2) ? 1 : $clog2(BEACON_LEN);
  localparam logic [CW-1:0] LAST = CW'(BEACON_LEN - 1);

  seq_t          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (in_deep && start) begin
          st_d   = SEQ_RUN;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (!in_deep || cnt_q == LAST) begin
          st_d = SEQ_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    active_nxt = (st_d == SEQ_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_beacon_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && cnt_q == LAST) |=> (st_q == SEQ_IDLE));
  p_leave_cancels_beacon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_deep) |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/pwr_tx_ctrl.sv
module pwr_tx_ctrl
  import pwr_tx_pkg::*;
#(
  parameter int unsigned DET_TIMEOUT = 255,
  parameter int unsigned BEACON_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state,
  input  logic       req_loop,
  input  logic       req_detect,
  input  logic       req_beacon,
  input  logic       detect_status_valid,
  output logic       tx_detect_loop,
  output logic       tx_elec_idle,
  output logic       illegal_req,
  output logic       detect_done,
  output logic       detect_timeout
);
  logic in_full, in_lowidle, in_deep, illegal_now;
  logic det_busy_nxt, bcn_active_nxt;
  logic dl_d, idle_d;

  pwr_state_map u_map (
    .pwr_state  (pwr_state),
    .req_loop   (req_loop),
    .req_detect (req_detect),
    .req_beacon (req_beacon),
    .in_full    (in_full),
    .in_lowidle (in_lowidle),
    .in_deep    (in_deep),
    .illegal    (illegal_now)
  );

  pwr_detect_seq #(.DET_TIMEOUT(DET_TIMEOUT)) u_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_lowidle   (in_lowidle),
    .start        (req_detect),
    .status_valid (detect_status_valid),
    .busy_nxt     (det_busy_nxt),
    .done_q       (detect_done),
    .timeout_q    (detect_timeout)
  );

  pwr_beacon_tmr #(.BEACON_LEN(BEACON_LEN)) u_bcn (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_deep    (in_deep),
    .start      (req_beacon),
    .active_nxt (bcn_active_nxt)
  );

  always_comb begin
    dl_d   = 1'b0;
    idle_d = 1'b1;
    if (in_full) begin
      dl_d   = req_loop;
      idle_d = 1'b0;
    end else if (in_lowidle) begin
      dl_d   = det_busy_nxt;
    end else if (in_deep) begin
      idle_d = !bcn_active_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_detect_loop <= 1'b1;
      tx_elec_idle   <= 1'b1;
      illegal_req    <= 1'b0;
    end else begin
      tx_detect_loop <= dl_d;
      tx_elec_idle   <= idle_d;
      illegal_req    <= illegal_now;
    end
  end

  p_full_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00) |=> (!tx_elec_idle && tx_detect_loop == $past(req_loop)));
  p_dl_low_r3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[0]) |=> (!tx_detect_loop));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01 || pwr_state == 2'b10) |=> tx_elec_idle);
  p_illegal_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_loop && pwr_state != 2'b00) |=> illegal_req);
  p_timeout_has_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    detect_timeout |-> detect_done);
endmodule

// File: tb/sim_pwr_tx_ctrl.sv
module sim_pwr_tx_ctrl;
  localparam int unsigned DET_T = 255;
  localparam int unsigned BCN_L = 16;
  localparam int NVEC = 11;
  // row fields: [7:6] state, [5] loop, [4] detect, [3] beacon, [2] exp dl, [1] exp idle, [0] exp illegal
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00100100,  // R2 loopback
    8'b00000000,  // R2 normal
    8'b01000010,  // R3
    8'b01100011,  // R3 R6
    8'b10000010,  // R4
    8'b10100011,  // R6
    8'b11000010,  // R5
    8'b11100011,  // R6
    8'b11010011,  // R6
    8'b00001001,  // R6
    8'b00111101   // R2 R6
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] pwr_state;
  logic req_loop, req_detect, req_beacon, detect_status_valid;
  logic tx_detect_loop, tx_elec_idle, illegal_req, detect_done, detect_timeout;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_tx_ctrl #(.DET_TIMEOUT(DET_T), .BEACON_LEN(BCN_L)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .req_loop(req_loop),
    .req_detect(req_detect), .req_beacon(req_beacon),
    .detect_status_valid(detect_status_valid), .tx_detect_loop(tx_detect_loop),
    .tx_elec_idle(tx_elec_idle), .illegal_req(illegal_req),
    .detect_done(detect_done), .detect_timeout(detect_timeout)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int outs();
    return {tx_detect_loop, tx_elec_idle, illegal_req, detect_done, detect_timeout};
  endfunction

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0;
    pwr_state = 2'b10;
    req_loop = 0; req_detect = 0; req_beacon = 0; detect_status_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 5'b11000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {pwr_state, req_loop, req_detect, req_beacon} = VEC[i][7:3];
      @(negedge clk);
      $display("row %0d (R2 R3 R4 R5 R6)", i);
      check("R2 R3 R4 R5 R6 table", {tx_detect_loop, tx_elec_idle, illegal_req}, int'(VEC[i][2:0]));
    end
    {req_loop, req_detect, req_beacon} = 3'b000;

    // R7: detect ends on status
    pwr_state = 2'b10;
    @(negedge clk);
    req_detect = 1;
    @(negedge clk);
    req_detect = 0;
    check("R7 line raised", tx_detect_loop, 1);
    repeat (3) @(negedge clk);
    check("R7 line held", {tx_detect_loop, detect_done}, 2'b10);
    detect_status_valid = 1;
    @(negedge clk);
    detect_status_valid = 0;
    check("R7 done no timeout", {tx_detect_loop, detect_done, detect_timeout}, 3'b010);
    @(negedge clk);
    check("R7 done one cycle", detect_done, 0);

    // R8 + R11: timeout, with a repeated request mid-way
    req_detect = 1;
    @(negedge clk);
    req_detect = 0;
    n = 0;
    while (tx_detect_loop && n < 1000) begin
      n++;
      if (n == 10) req_detect = 1;
      else req_detect = 0;
      @(negedge clk);
    end
    req_detect = 0;
    check("R8 R11 high cycles", n, DET_T);
    check("R8 done and timeout", {detect_done, detect_timeout}, 2'b11);
    @(negedge clk);
    check("R8 pulse one cycle", {detect_done, detect_timeout}, 2'b00);

    // R9: beacon window
    pwr_state = 2'b11;
    @(negedge clk);
    req_beacon = 1;
    @(negedge clk);
    req_beacon = 0;
    n = 0;
    while (!tx_elec_idle && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R9 beacon length", n, BCN_L);
    check("R9 idle restored", {tx_elec_idle, illegal_req}, 2'b10);

    // R10: cancel detect by leaving low-power idle
    pwr_state = 2'b10;
    @(negedge clk);
    req_detect = 1;
    @(negedge clk);
    req_detect = 0;
    repeat (4) @(negedge clk);
    pwr_state = 2'b00;
    @(negedge clk);
    check("R10 detect cancelled", {tx_detect_loop, detect_done}, 2'b00);
    pwr_state = 2'b10;
    repeat (2) @(negedge clk);
    check("R10 detect not resumed", {tx_detect_loop, detect_done}, 2'b00);

    // R10: cancel beacon by leaving deep sleep
    pwr_state = 2'b11;
    @(negedge clk);
    req_beacon = 1;
    @(negedge clk);
    req_beacon = 0;
    repeat (2) @(negedge clk);
    pwr_state = 2'b01;
    @(negedge clk);
    check("R10 beacon cancelled", tx_elec_idle, 1);
    pwr_state = 2'b11;
    repeat (2) @(negedge clk);
    check("R10 beacon not resumed", tx_elec_idle, 1);

    // R1: reset mid-operation
    pwr_state = 2'b00;
    req_loop = 1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", outs(), 5'b11000);
    @(negedge clk);
    rst_n = 1'b1;
    req_loop = 0;
    @(negedge clk);
    check("R2 after reset", {tx_detect_loop, tx_elec_idle}, 2'b00);

    finish_run();
  end
endmodule